// File: doc/BRIEF.md
# Ones-Complement Accumulator Arithmetic Unit

This unit performs the word arithmetic of a small accumulator machine whose numbers are 15-bit ones-complement values: a negative number is the bitwise inverse of its magnitude, so both a positive zero (all bits clear) and a negative zero (all bits set) exist. The sequencer supplies the accumulator word, a memory operand and an operation code with a valid strobe. In the same cycle the unit returns the result word and tells whether it goes to the accumulator or back to memory. Every addition feeds its carry out of the top bit back into the least significant bit.

The accumulator holds one bit more than a memory word, which records a sign overflow. This unit owns that bit as a three-state machine. ACC_CLEAN means no overflow is held. ACC_OVF_POS means the last accumulator sum left the positive range. ACC_OVF_NEG means it left the negative range. An add or subtract moves the machine to the state its sum calls for, which can be ACC_CLEAN. A complement-load or a store returns it to ACC_CLEAN. Every other operation, and every idle cycle, leaves it where it is. A store made while an overflow is held also emits a signed-carry word for the next higher memory word, which turns the stored value into a double word. The unit also classifies operands for the four-way count-compare-skip and for the two conditional jumps.

Top module: `oc_arith_unit`

## Requirements
- R1: After reset the overflow state is ACC_CLEAN: `ovf_flag` and `ovf_neg` are 0, and `carry_we` is 0.
- R2: With code 1 (add), `result` is `acc_in + mem_in` in ones complement with end-around carry, and `acc_we` is 1.
- R3: With code 2 (subtract), `result` is `acc_in` plus the bitwise inverse of `mem_in` through the same adder, so x minus x gives negative zero (0x7FFF). `acc_we` is 1.
- R4: An add or subtract of two operands with bit 14 clear that gives bit 14 set moves the state to ACC_OVF_POS (`ovf_flag`=1, `ovf_neg`=0) on the next cycle. Two operands with bit 14 set that give bit 14 clear move it to ACC_OVF_NEG (`ovf_flag`=1, `ovf_neg`=1). An add or subtract that does not overflow moves it to ACC_CLEAN.
- R5: With code 3 (complement-load), `result` is the bitwise inverse of `mem_in`, `acc_we` is 1, and the state becomes ACC_CLEAN on the next cycle.
- R6: With code 4 (increment), `result` is `mem_in + 1` with end-around carry, `mem_we` is 1, and the overflow state is unchanged.
- R7: With code 5 (magnitude increment), a word with bit 14 clear gets +1 and a word with bit 14 set gets −1. With code 6 (magnitude decrement), a word with bit 14 clear gets −1 and a word with bit 14 set gets +1. Decrement leaves both zeros unchanged and takes +1 to +0. Both codes assert `mem_we` and leave the overflow state unchanged.
- R8: `ccs_offset` classifies `mem_in`: 0 for greater than +0, 1 for +0, 2 for less than −0 (bit 14 set, not all ones), 3 for −0. Code 7 writes nothing and leaves the overflow state unchanged.
- R9: With code 8 (store), `result` is `acc_in` with `mem_we` 1. If an overflow is held, `carry_we` is 1 and `carry_word` is 0x0001 for ACC_OVF_POS and 0x7FFE (−1) for ACC_OVF_NEG. The state is ACC_CLEAN on the next cycle.
- R10: `jz_take` is 1 only when `acc_in` is +0. `jlez_take` is 1 when `acc_in` is +0, −0 or has bit 14 set.
- R11: While `op_valid` is 0, or for any code above 8, `acc_we`, `mem_we` and `carry_we` stay 0 and the overflow state is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe for this cycle |
| op_code | input | 4 | Operation code (0 none, 1 add, 2 subtract, 3 complement-load, 4 increment, 5 magnitude increment, 6 magnitude decrement, 7 count-compare-skip, 8 store) |
| acc_in | input | 15 | Accumulator word |
| mem_in | input | 15 | Memory operand |
| result | output | 15 | Result word |
| acc_we | output | 1 | Result goes to the accumulator |
| mem_we | output | 1 | Result goes to the operand's memory word |
| carry_word | output | 15 | Signed-carry word for the next higher memory word |
| carry_we | output | 1 | Write `carry_word` during this store |
| ovf_flag | output | 1 | An overflow is held |
| ovf_neg | output | 1 | The held overflow is negative |
| ccs_offset | output | 2 | Count-compare-skip class of `mem_in` |
| jz_take | output | 1 | Jump-if-zero taken |
| jlez_take | output | 1 | Jump-if-less-or-zero taken |

## Verification
The overflow assertions assume that a word's sign is bit 14 and that only add and subtract can move the state into an overflow state. They also assume that `op_code` holds a defined value whenever `op_valid` is high. The directed stimulus changes inputs only at falling edges and holds each operation for one whole cycle, so every rising edge samples a single settled operation. Before each store it sets up a known overflow state with a chosen add. Operands are picked at the range limits (0x3FFF, 0x4000, both zeros, ±1) so that carries wrap and overflows fire in both directions.

// File: rtl/oc_arith_pkg.sv
package oc_arith_pkg;
    localparam int WORD_W = 15;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_ADD   = 4'd1,
        OP_SUB   = 4'd2,
        OP_LDC   = 4'd3,
        OP_INC   = 4'd4,
        OP_AUG   = 4'd5,
        OP_DIM   = 4'd6,
        OP_CCS   = 4'd7,
        OP_STORE = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        ACC_CLEAN   = 2'd0,
        ACC_OVF_POS = 2'd1,
        ACC_OVF_NEG = 2'd2
    } acc_state_e;

    typedef enum logic [1:0] {
        CLS_POS   = 2'd0,
        CLS_PZERO = 2'd1,
        CLS_NEG   = 2'd2,
        CLS_NZERO = 2'd3
    } sign_cls_e;
endpackage

// File: rtl/oc_ec_adder.sv
module oc_ec_adder #(
    parameter int W = 15
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         ovf_pos,
    output logic         ovf_neg
);
    logic [W:0] raw;

    always_comb begin
        raw     = {1'b0, a} + {1'b0, b};
        // carry out re-enters at bit 0; a second carry cannot arise
        sum     = raw[W-1:0] + W'(raw[W]);
        ovf_pos = !a[W-1] && !b[W-1] &&  sum[W-1];
        ovf_neg =  a[W-1] &&  b[W-1] && !sum[W-1];
    end
endmodule

// File: rtl/oc_sign_class.sv
module oc_sign_class #(
    parameter int W = 15
) (
    input  logic [W-1:0]                word,
    output oc_arith_pkg::sign_cls_e     cls,
    output logic                        is_pzero,
    output logic                        is_nzero,
    output logic                        is_neg
);
    import oc_arith_pkg::*;

    always_comb begin
        is_pzero = (word == '0);
        is_nzero = &word;
        is_neg   = word[W-1];
        if (is_pzero)      cls = CLS_PZERO;
        else if (is_nzero) cls = CLS_NZERO;
        else if (is_neg)   cls = CLS_NEG;
        else               cls = CLS_POS;
    end
endmodule

// File: rtl/oc_ovf_tracker.sv
module oc_ovf_tracker (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic [3:0] op_code,
    input  logic       sum_ovf_pos,
    input  logic       sum_ovf_neg,
    output logic       ovf_flag,
    output logic       ovf_neg
);
    import oc_arith_pkg::*;

    acc_state_e state_q, state_d;
    op_e        op;

    assign op = op_e'(op_code);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_CLEAN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (op_valid) begin
            unique case (op)
                OP_ADD, OP_SUB: begin
                    if (sum_ovf_pos)      state_d = ACC_OVF_POS;
                    else if (sum_ovf_neg) state_d = ACC_OVF_NEG;
                    else                  state_d = ACC_CLEAN;
                end
                OP_LDC, OP_STORE: state_d = ACC_CLEAN;
                default:          state_d = state_q;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ACC_OVF_POS: begin ovf_flag = 1'b1; ovf_neg = 1'b0; end
            ACC_OVF_NEG: begin ovf_flag = 1'b1; ovf_neg = 1'b1; end
            default:     begin ovf_flag = 1'b0; ovf_neg = 1'b0; end
        endcase
    end
endmodule

// File: rtl/oc_arith_unit.sv
module oc_arith_unit #(
    parameter int W = oc_arith_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [3:0]   op_code,
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] mem_in,
    output logic [W-1:0] result,
    output logic         acc_we,
    output logic         mem_we,
    output logic [W-1:0] carry_word,
    output logic         carry_we,
    output logic         ovf_flag,
    output logic         ovf_neg,
    output logic [1:0]   ccs_offset,
    output logic         jz_take,
    output logic         jlez_take
);
    import oc_arith_pkg::*;

    localparam logic [W-1:0] PLUS_ONE  = W'(1);
    localparam logic [W-1:0] MINUS_ONE = ~PLUS_ONE;

    op_e          op;
    logic [W-1:0] add_a, add_b, add_sum;
    logic         add_ovf_pos, add_ovf_neg;
    sign_cls_e    mem_cls, acc_cls;
    logic         mem_pz, mem_nz, mem_neg;
    logic         acc_pz, acc_nz, acc_neg;

    assign op = op_e'(op_code);

    always_comb begin
        add_a = acc_in;
        add_b = mem_in;
        unique case (op)
            OP_SUB: add_b = ~mem_in;
            OP_INC: begin add_a = mem_in; add_b = PLUS_ONE; end
            OP_AUG: begin add_a = mem_in; add_b = mem_neg ? MINUS_ONE : PLUS_ONE; end
            OP_DIM: begin add_a = mem_in; add_b = mem_neg ? PLUS_ONE : MINUS_ONE; end
            default: ;
        endcase
    end

    oc_ec_adder #(.W(W)) adder_i (
        .a       (add_a),
        .b       (add_b),
        .sum     (add_sum),
        .ovf_pos (add_ovf_pos),
        .ovf_neg (add_ovf_neg)
    );

    oc_sign_class #(.W(W)) mem_cls_i (
        .word     (mem_in),
        .cls      (mem_cls),
        .is_pzero (mem_pz),
        .is_nzero (mem_nz),
        .is_neg   (mem_neg)
    );

    oc_sign_class #(.W(W)) acc_cls_i (
        .word     (acc_in),
        .cls      (acc_cls),
        .is_pzero (acc_pz),
        .is_nzero (acc_nz),
        .is_neg   (acc_neg)
    );

    oc_ovf_tracker tracker_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_valid    (op_valid),
        .op_code     (op_code),
        .sum_ovf_pos (add_ovf_pos),
        .sum_ovf_neg (add_ovf_neg),
        .ovf_flag    (ovf_flag),
        .ovf_neg     (ovf_neg)
    );

    always_comb begin
        result     = add_sum;
        acc_we     = 1'b0;
        mem_we     = 1'b0;
        carry_we   = 1'b0;
        carry_word = ovf_neg ? MINUS_ONE : PLUS_ONE;
        if (op_valid) begin
            unique case (op)
                OP_ADD, OP_SUB: acc_we = 1'b1;
                OP_LDC: begin
                    result = ~mem_in;
                    acc_we = 1'b1;
                end
                OP_INC, OP_AUG: mem_we = 1'b1;
                OP_DIM: begin
                    mem_we = 1'b1;
                    if (mem_pz || mem_nz)          result = mem_in;
                    else if (!mem_neg && &add_sum) result = '0;
                end
                OP_CCS: result = mem_in;
                OP_STORE: begin
                    result   = acc_in;
                    mem_we   = 1'b1;
                    carry_we = ovf_flag;
                end
                default: ;
            endcase
        end
    end

    assign ccs_offset = mem_cls;
    assign jz_take    = (acc_cls == CLS_PZERO);
    assign jlez_take  = acc_pz || acc_nz || acc_neg;
endmodule

// File: rtl/oc_arith_chk.sv
module oc_arith_chk #(
    parameter int W = 15
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_valid,
    input logic [3:0]   op_code,
    input logic [W-1:0] acc_in,
    input logic [W-1:0] mem_in,
    input logic [W-1:0] result,
    input logic         acc_we,
    input logic         mem_we,
    input logic         carry_we,
    input logic         ovf_flag,
    input logic         ovf_neg,
    input logic         jz_take
);
    AST_STORE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd8) |=> !ovf_flag); // R9
    AST_CARRY_NEEDS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        carry_we |-> (ovf_flag && op_valid)); // R9
    AST_LDC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd3) |=> !ovf_flag); // R5
    AST_POS_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd1 && !acc_in[W-1] && !mem_in[W-1] && result[W-1])
        |=> (ovf_flag && !ovf_neg)); // R4
    AST_NEG_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd1 && acc_in[W-1] && mem_in[W-1] && !result[W-1])
        |=> (ovf_flag && ovf_neg)); // R4
    AST_MEM_OPS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd4 && op_code <= 4'd7)
        |=> ($stable(ovf_flag) && $stable(ovf_neg))); // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(ovf_flag) && $stable(ovf_neg))); // R11
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |-> (!acc_we && !mem_we && !carry_we)); // R11
    AST_JZ_PLUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        jz_take |-> (acc_in == '0)); // R10
endmodule

bind oc_arith_unit oc_arith_chk #(.W(W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .acc_in   (acc_in),
    .mem_in   (mem_in),
    .result   (result),
    .acc_we   (acc_we),
    .mem_we   (mem_we),
    .carry_we (carry_we),
    .ovf_flag (ovf_flag),
    .ovf_neg  (ovf_neg),
    .jz_take  (jz_take)
);

// File: tb/oc_arith_unit_tb_top.sv
module oc_arith_unit_tb_top;
    localparam int W = 15;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [3:0]   op_code = 4'd0;
    logic [W-1:0] acc_in = '0;
    logic [W-1:0] mem_in = '0;
    logic [W-1:0] result, carry_word;
    logic         acc_we, mem_we, carry_we, ovf_flag, ovf_neg, jz_take, jlez_take;
    logic [1:0]   ccs_offset;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    oc_arith_unit #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .acc_in(acc_in), .mem_in(mem_in), .result(result), .acc_we(acc_we),
        .mem_we(mem_we), .carry_word(carry_word), .carry_we(carry_we),
        .ovf_flag(ovf_flag), .ovf_neg(ovf_neg), .ccs_offset(ccs_offset),
        .jz_take(jz_take), .jlez_take(jlez_take)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] code, input logic [W-1:0] a, input logic [W-1:0] m);
        @(negedge clk);
        op_valid = 1'b1; op_code = code; acc_in = a; mem_in = m;
        #1;
    endtask

    task automatic retire();
        @(posedge clk);
        #1;
        op_valid = 1'b0;
        #1;
    endtask

    task automatic t_reset();
        check("R1 ovf_flag", ovf_flag, 0);
        check("R1 ovf_neg", ovf_neg, 0);
        check("R1 carry_we", carry_we, 0);
    endtask

    task automatic t_add();
        drive(4'd1, 15'h0003, 15'h7FFA);
        check("R2 3+(-5)", result, 15'h7FFD);
        check("R2 acc_we", acc_we, 1);
        retire();
        drive(4'd1, 15'h0006, 15'h7FFB);
        check("R2 end-around 6+(-4)", result, 15'h0002);
        retire();
        check("R4 no overflow clean", ovf_flag, 0);
    endtask

    task automatic t_sub();
        drive(4'd2, 15'h0006, 15'h0004);
        check("R3 6-4", result, 15'h0002);
        retire();
        drive(4'd2, 15'h0004, 15'h0006);
        check("R3 4-6", result, 15'h7FFD);
        retire();
        drive(4'd2, 15'h0005, 15'h0005);
        check("R3 5-5 negative zero", result, 15'h7FFF);
        check("R3 acc_we", acc_we, 1);
        retire();
    endtask

    task automatic t_ovf_store();
        drive(4'd1, 15'h3FFF, 15'h0001);
        check("R4 pos overflow sum", result, 15'h4000);
        retire();
        check("R4 pos flag", ovf_flag, 1);
        check("R4 pos sign", ovf_neg, 0);
        drive(4'd4, 15'h0000, 15'h0010);
        retire();
        check("R6 inc holds flag", ovf_flag, 1);
        drive(4'd8, 15'h4000, 15'h0000);
        check("R9 store word", result, 15'h4000);
        check("R9 store mem_we", mem_we, 1);
        check("R9 carry_we pos", carry_we, 1);
        check("R9 carry +1", carry_word, 15'h0001);
        retire();
        check("R9 cleared after store", ovf_flag, 0);
        drive(4'd1, 15'h4000, 15'h7FFE);
        check("R4 neg overflow sum", result, 15'h3FFF);
        retire();
        check("R4 neg flag", ovf_flag, 1);
        check("R4 neg sign", ovf_neg, 1);
        drive(4'd8, 15'h3FFF, 15'h0000);
        check("R9 carry_we neg", carry_we, 1);
        check("R9 carry -1", carry_word, 15'h7FFE);
        retire();
        check("R9 cleared neg", ovf_flag, 0);
        drive(4'd8, 15'h0123, 15'h0000);
        check("R9 no carry when clean", carry_we, 0);
        retire();
        drive(4'd2, 15'h3FFF, 15'h7FFE);
        retire();
        check("R4 sub overflow", ovf_flag, 1);
        drive(4'd2, 15'h0001, 15'h0001);
        retire();
        check("R4 sub no overflow clears", ovf_flag, 0);
    endtask

    task automatic t_ldc();
        drive(4'd1, 15'h3FFF, 15'h0001);
        retire();
        drive(4'd3, 15'h0000, 15'h1234);
        check("R5 complement", result, 15'h6DCB);
        check("R5 acc_we", acc_we, 1);
        retire();
        check("R5 clears overflow", ovf_flag, 0);
    endtask

    task automatic t_inc();
        drive(4'd4, 15'h0000, 15'h0010);
        check("R6 inc", result, 15'h0011);
        check("R6 mem_we", mem_we, 1);
        check("R6 acc_we", acc_we, 0);
        retire();
        drive(4'd4, 15'h0000, 15'h7FFF);
        check("R6 inc of -0", result, 15'h0001);
        retire();
    endtask

    task automatic t_aug_dim();
        drive(4'd5, 0, 15'h0005); check("R7 aug +5", result, 15'h0006); check("R7 aug mem_we", mem_we, 1); retire();
        drive(4'd5, 0, 15'h7FFA); check("R7 aug -5", result, 15'h7FF9); retire();
        drive(4'd5, 0, 15'h0000); check("R7 aug +0", result, 15'h0001); retire();
        drive(4'd5, 0, 15'h7FFF); check("R7 aug -0", result, 15'h7FFE); retire();
        drive(4'd6, 0, 15'h0005); check("R7 dim +5", result, 15'h0004); retire();
        drive(4'd6, 0, 15'h7FFA); check("R7 dim -5", result, 15'h7FFB); retire();
        drive(4'd6, 0, 15'h0001); check("R7 dim +1", result, 15'h0000); retire();
        drive(4'd6, 0, 15'h7FFE); check("R7 dim -1", result, 15'h7FFF); retire();
        drive(4'd6, 0, 15'h0000); check("R7 dim +0", result, 15'h0000); retire();
        drive(4'd6, 0, 15'h7FFF); check("R7 dim -0", result, 15'h7FFF); check("R7 dim mem_we", mem_we, 1); retire();
        drive(4'd1, 15'h3FFF, 15'h0001); retire();
        drive(4'd5, 0, 15'h0003); retire();
        check("R7 aug holds flag", ovf_flag, 1);
        drive(4'd6, 0, 15'h0003); retire();
        check("R7 dim holds flag", ovf_flag, 1);
        drive(4'd3, 0, 0); retire();
    endtask

    task automatic t_ccs();
        drive(4'd7, 0, 15'h0005); check("R8 positive", ccs_offset, 0); check("R8 no write", mem_we | acc_we, 0); retire();
        drive(4'd7, 0, 15'h0000); check("R8 +0", ccs_offset, 1); retire();
        drive(4'd7, 0, 15'h7FFA); check("R8 negative", ccs_offset, 2); retire();
        drive(4'd7, 0, 15'h7FFF); check("R8 -0", ccs_offset, 3); retire();
        check("R8 state unchanged", ovf_flag, 0);
    endtask

    task automatic t_jump();
        drive(4'd0, 15'h0000, 0); check("R10 jz +0", jz_take, 1); check("R10 jlez +0", jlez_take, 1); retire();
        drive(4'd0, 15'h7FFF, 0); check("R10 jz -0", jz_take, 0); check("R10 jlez -0", jlez_take, 1); retire();
        drive(4'd0, 15'h0005, 0); check("R10 jz pos", jz_take, 0); check("R10 jlez pos", jlez_take, 0); retire();
        drive(4'd0, 15'h7FFA, 0); check("R10 jlez neg", jlez_take, 1); retire();
    endtask

    task automatic t_ignore();
        drive(4'd1, 15'h3FFF, 15'h0001); retire();
        drive(4'd15, 15'h0001, 15'h0001);
        check("R11 bad code writes", {acc_we, mem_we, carry_we}, 0);
        retire();
        check("R11 bad code holds", ovf_flag, 1);
        @(negedge clk);
        op_valid = 1'b0; op_code = 4'd8; acc_in = 15'h0001;
        #1;
        check("R11 idle store writes", {acc_we, mem_we, carry_we}, 0);
        @(posedge clk); #1;
        check("R11 idle holds", ovf_flag, 1);
        drive(4'd3, 0, 0); retire();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_add();
        t_sub();
        t_ovf_store();
        t_ldc();
        t_inc();
        t_aug_dim();
        t_ccs();
        t_jump();
        t_ignore();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule